// File: doc/BRIEF.md
# Indexed GPIO Register Window

This block exposes a bank of fifteen 8-bit general purpose output registers through a two-location byte port. Software first writes a register number to the index location. Accesses to the data location then read or write the register that the index selects. Reading the index location returns whatever byte was last stored there. Every register's current value is also driven in parallel on a wide output vector, so the logic next to the block sees a register change one cycle after the write that made it.

Register numbers run from 1 to 15. Index 0 and every index from 16 to 255 point at nothing. A data write there is dropped, and a data read there returns 0xFF. The index itself stores any byte, and only the decode treats out-of-range values differently. Read data comes from a register: it appears on the cycle after the read strobe and holds until the next read.

Top module: `gpio_window`

## Requirements
- R1: A write with `sel_data`=0 stores all eight bits of `wdata` as the index, for any value 0..255. A later read with `sel_data`=0 returns that byte.
- R2: A write with `sel_data`=1 while the index is n, with 1 <= n <= 15, loads `wdata` into register n. Register n is driven on `gpio_out[8n-1:8n-8]` from the next clock edge.
- R3: A write with `sel_data`=1 while the index is 0 or greater than 15 changes no register.
- R4: A read with `sel_data`=1 while the index is n, with 1 <= n <= 15, returns the contents of register n.
- R5: A read with `sel_data`=1 while the index is 0 or greater than 15 returns 0xFF.
- R6: After reset, every register is 0 except register 2, which is 0xFD. The index is 0 and `rdata` is 0.
- R7: `rdata` is registered. It takes its new value at the clock edge that samples `rd_en`=1 and keeps that value while `rd_en` is 0.
- R8: A data-location write does not change the index.
- R9: A data write to register n leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_data | input | 1 | 0 selects the index location, 1 selects the data location |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| gpio_out | output | 120 | Register n on bits [8n-1:8n-8], for n = 1..15 |

## Verification
The assertions assume that the bus never writes and reads the same location in the same cycle. They also assume that the strobes and the select are known whenever reset is released. The data-write property relies on the index holding steady across a data write. The stimulus keeps to this: each task raises exactly one strobe for a single cycle, driven on the falling edge, with an idle cycle between accesses. It also covers the boundary indices 0, 1, 15, 16 and 255.

// File: rtl/gpio_window_pkg.sv
package gpio_window_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // decoded bus access for one cycle
    typedef struct packed {
        logic idx_wr;
        logic idx_rd;
        logic dat_wr;
        logic dat_rd;
    } access_t;

    // index register state
    typedef struct packed {
        byte_t idx;
    } idx_state_t;

    // read path state
    typedef struct packed {
        byte_t rdata;
    } rd_state_t;

endpackage

// File: rtl/gpio_window_index.sv
module gpio_window_index
    import gpio_window_pkg::*;
#(
    parameter int NUM_REGS = 15
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  byte_t load_val,
    output byte_t idx,
    output logic  in_range
);

    idx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.idx = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx      = st_q.idx;
    // register numbers start at 1; 0 and anything past the bank select nothing
    assign in_range = (st_q.idx != '0) && (int'(st_q.idx) <= NUM_REGS);

endmodule

// File: rtl/gpio_window_bank.sv
module gpio_window_bank
    import gpio_window_pkg::*;
#(
    parameter int    NUM_REGS   = 15,
    parameter int    PRESET_IDX = 2,
    parameter byte_t PRESET_VAL = 8'hFD
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr,
    input  logic                             in_range,
    input  byte_t                            idx,
    input  byte_t                            wdata,
    output logic [NUM_REGS-1:0][BYTE_W-1:0]  regs
);

    logic [NUM_REGS-1:0][BYTE_W-1:0] regs_d, regs_q;
    logic [NUM_REGS-1:0]             hit;

    // one-hot write select, slot k holds register k+1
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_slot
        localparam byte_t SLOT_NUM = byte_t'(k + 1);
        localparam byte_t SLOT_RST = (k + 1 == PRESET_IDX) ? PRESET_VAL : '0;

        assign hit[k] = wr && in_range && (idx == SLOT_NUM);

        always_comb begin
            regs_d[k] = hit[k] ? wdata : regs_q[k];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[k] <= SLOT_RST;
            end else begin
                regs_q[k] <= regs_d[k];
            end
        end
    end

    assign regs = regs_q;

endmodule

// File: rtl/gpio_window_rdpath.sv
module gpio_window_rdpath
    import gpio_window_pkg::*;
#(
    parameter int    NUM_REGS = 15,
    parameter byte_t MISS_VAL = 8'hFF
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             idx_rd,
    input  logic                             dat_rd,
    input  byte_t                            idx,
    input  logic                             in_range,
    input  logic [NUM_REGS-1:0][BYTE_W-1:0]  regs,
    output byte_t                            rdata
);

    rd_state_t st_d, st_q;
    byte_t     sel_byte;

    // selected register, or the miss value outside the bank
    always_comb begin
        sel_byte = MISS_VAL;
        if (in_range) begin
            sel_byte = '0;
            for (int k = 0; k < NUM_REGS; k++) begin
                if (idx == byte_t'(k + 1)) begin
                    sel_byte = regs[k];
                end
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (idx_rd) begin
            st_d.rdata = idx;
        end else if (dat_rd) begin
            st_d.rdata = sel_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

endmodule

// File: rtl/gpio_window.sv
module gpio_window
    import gpio_window_pkg::*;
#(
    parameter int   NUM_REGS   = 15,
    parameter int   PRESET_IDX = 2,
    parameter logic [7:0] PRESET_VAL = 8'hFD,
    parameter logic [7:0] MISS_VAL   = 8'hFF,
    localparam int  OUT_W      = NUM_REGS * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_data,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic [OUT_W-1:0] gpio_out
);

    access_t                         acc;
    byte_t                           idx;
    logic                            in_range;
    logic [NUM_REGS-1:0][BYTE_W-1:0] regs;

    always_comb begin
        acc        = '0;
        acc.idx_wr = wr_en && !sel_data;
        acc.idx_rd = rd_en && !sel_data;
        acc.dat_wr = wr_en &&  sel_data;
        acc.dat_rd = rd_en &&  sel_data;
    end

    gpio_window_index #(
        .NUM_REGS (NUM_REGS)
    ) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (acc.idx_wr),
        .load_val (wdata),
        .idx      (idx),
        .in_range (in_range)
    );

    gpio_window_bank #(
        .NUM_REGS   (NUM_REGS),
        .PRESET_IDX (PRESET_IDX),
        .PRESET_VAL (PRESET_VAL)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (acc.dat_wr),
        .in_range (in_range),
        .idx      (idx),
        .wdata    (wdata),
        .regs     (regs)
    );

    gpio_window_rdpath #(
        .NUM_REGS (NUM_REGS),
        .MISS_VAL (MISS_VAL)
    ) u_rdpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_rd   (acc.idx_rd),
        .dat_rd   (acc.dat_rd),
        .idx      (idx),
        .in_range (in_range),
        .regs     (regs),
        .rdata    (rdata)
    );

    assign gpio_out = regs;

endmodule

// File: rtl/gpio_window_checker.sv
module gpio_window_checker #(
    parameter int NUM_REGS = 15,
    localparam int OUT_W   = NUM_REGS * 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_data,
    input logic             wr_en,
    input logic             rd_en,
    input logic [7:0]       wdata,
    input logic [7:0]       rdata,
    input logic [OUT_W-1:0] gpio_out,
    input logic [7:0]       idx
);

    logic       idx_ok;
    logic [7:0] cur_byte;

    assign idx_ok = (idx != 8'd0) && (int'(idx) <= NUM_REGS);

    always_comb begin
        cur_byte = 8'h00;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (int'(idx) == k + 1) begin
                cur_byte = gpio_out[k*8 +: 8];
            end
        end
    end

    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_data) |=> (idx == $past(wdata)));                           // R1

    AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_data && idx_ok && !rd_en) |=> (cur_byte == $past(wdata)));    // R2

    AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_data && !idx_ok) |=> $stable(gpio_out));                     // R3

    AST_MISS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel_data && !wr_en && !idx_ok) |=> (rdata == 8'hFF));             // R5

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));                                                // R7

    AST_IDX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_data) |=> $stable(idx));                                     // R8

endmodule

bind gpio_window gpio_window_checker #(
    .NUM_REGS (NUM_REGS)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_data (sel_data),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .rdata    (rdata),
    .gpio_out (gpio_out),
    .idx      (idx)
);

// File: tb/gpio_window_tb_top.sv
module gpio_window_tb_top;

    localparam int N = 15;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sel_data = 1'b0;
    logic           wr_en = 1'b0;
    logic           rd_en = 1'b0;
    logic [7:0]     wdata = 8'h00;
    logic [7:0]     rdata;
    logic [N*8-1:0] gpio_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] model [1:N];

    always #5 clk = ~clk;

    gpio_window dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_data (sel_data),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata    (wdata),
        .rdata    (rdata),
        .gpio_out (gpio_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic sel, input logic [7:0] val);
        @(negedge clk);
        sel_data = sel; wdata = val; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel && val !== 8'hxx) begin end
    endtask

    task automatic bus_rd(input logic sel, output logic [7:0] val);
        @(negedge clk);
        sel_data = sel; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        val = rdata;
    endtask

    // write through the window and track the model
    task automatic data_wr(input logic [7:0] idx, input logic [7:0] val);
        bus_wr(1'b0, idx);
        bus_wr(1'b1, val);
        if (idx >= 1 && idx <= N) model[idx] = val;
    endtask

    task automatic check_all_outputs(input string req);
        for (int n = 1; n <= N; n++) begin
            check(req, gpio_out[n*8-1 -: 8], model[n]);
        end
    endtask

    task automatic t_reset;
        for (int n = 1; n <= N; n++) model[n] = (n == 2) ? 8'hFD : 8'h00;
        check("R6 rdata", rdata, 8'h00);
        check_all_outputs("R6 regs");
        begin
            logic [7:0] v;
            bus_rd(1'b0, v);
            check("R6 index", v, 8'h00);
            bus_rd(1'b1, v);
            check("R6/R5 read at index 0", v, 8'hFF);
        end
    endtask

    task automatic t_index;
        logic [7:0] vals [4] = '{8'h00, 8'h07, 8'h10, 8'hFF};
        for (int i = 0; i < 4; i++) begin
            logic [7:0] v;
            bus_wr(1'b0, vals[i]);
            bus_rd(1'b0, v);
            check("R1 index readback", v, vals[i]);
        end
    endtask

    task automatic t_write_read;
        logic [7:0] v;
        data_wr(8'd1, 8'hA5);
        check("R2 reg1 out", gpio_out[7:0], 8'hA5);
        data_wr(8'd15, 8'h3C);
        check("R2 reg15 out", gpio_out[N*8-1 -: 8], 8'h3C);
        data_wr(8'd2, 8'h00);
        data_wr(8'd7, 8'h5A);
        check_all_outputs("R9 others unchanged");
        for (int n = 1; n <= N; n++) begin
            bus_wr(1'b0, 8'(n));
            bus_rd(1'b1, v);
            check("R4 data read", v, model[n]);
        end
        bus_wr(1'b0, 8'd9);
        bus_wr(1'b1, 8'h11);
        model[9] = 8'h11;
        bus_rd(1'b0, v);
        check("R8 index after data write", v, 8'd9);
    endtask

    task automatic t_miss;
        logic [7:0] idxs [3] = '{8'd0, 8'd16, 8'd255};
        for (int i = 0; i < 3; i++) begin
            logic [7:0] v;
            bus_wr(1'b0, idxs[i]);
            bus_wr(1'b1, 8'h77);
            check_all_outputs("R3 miss write ignored");
            bus_rd(1'b1, v);
            check("R5 miss read", v, 8'hFF);
        end
    endtask

    task automatic t_hold;
        logic [7:0] v;
        bus_wr(1'b0, 8'd7);
        @(negedge clk);
        sel_data = 1'b1; rd_en = 1'b1;
        #1 check("R7 not before edge", rdata, 8'hFF);
        @(negedge clk);
        rd_en = 1'b0;
        check("R7 after edge", rdata, model[7]);
        bus_wr(1'b1, 8'h99);
        model[7] = 8'h99;
        repeat (3) @(negedge clk);
        check("R7 hold without read", rdata, 8'h5A);
        bus_rd(1'b1, v);
        check("R7 new read", v, 8'h99);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_index();
        t_write_read();
        t_miss();
        t_hold();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule